// File: doc/BRIEF.md
# Insertion-Policy Recency Stack

This block keeps the replacement order for one set of a set-associative cache. The default set has 16 ways. Each way holds a rank: 0 means most recently used (MRU) and WAYS-1 means least recently used (LRU). The block always drives the current LRU way as the victim. On a hit, the hit way moves to MRU.

On a miss, the tag and data logic outside this block fill the victim way with the new line. The block then chooses where the new line enters the recency order, as selected by a 2-bit insertion mode:

- **Conventional insertion**: the new line enters at MRU and every other way ages by one.
- **LRU-slot insertion**: the new line stays at LRU. It reaches a younger position only if it is hit later.
- **Bimodal insertion**: a linear-feedback shift register (LFSR) drives a coin that sends about one miss in 32 to MRU. All other misses stay at LRU.

LRU-slot insertion protects the set against streaming accesses and against working sets that are larger than the cache. Bimodal insertion keeps most of that protection and still lets the resident lines follow a working set that changes over time.

Top module: `ips_recency_stack`

## Requirements
- R1: A synchronous active-low reset gives way i the rank i, so `victim_way` reads WAYS-1 after reset.
- R2: The ranks always form a permutation of 0..WAYS-1, so exactly one way holds rank WAYS-1, and `victim_way` is that way.
- R3: A valid hit on way h with rank r sets h to rank 0. Every way with a rank below r gains one rank. Ways with a rank above r keep their rank.
- R4: A valid miss with `ins_mode` = 0 moves the current victim way to rank 0 and adds one to the rank of every other way.
- R5: A valid miss with `ins_mode` = 1 leaves every rank unchanged, so the victim stays the same way.
- R6: A valid miss with `ins_mode` = 2 acts as in R4 when bits [4:0] of the LFSR, taken before it advances, are all zero. Otherwise it acts as in R5.
- R7: The LFSR is 16 bits wide and resets to 16'hACE1. On every valid miss, in any mode, it advances to {s[14:0], s[15]^s[13]^s[12]^s[10]}. It holds its value otherwise and is never zero.
- R8: `ins_mode` = 3 behaves exactly like `ins_mode` = 0.
- R9: While `acc_valid` is low, the ranks and the LFSR hold their values, whatever the other inputs are.
- R10: `victim_way` is derived from the registered ranks only. It reflects an access from the clock edge that ends that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access to the set occurs this cycle |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| hit_way | input | WAY_W | Way that hit; used only when `acc_hit` is 1 |
| ins_mode | input | 2 | 0 conventional, 1 LRU-slot, 2 bimodal, 3 same as 0 |
| victim_way | output | WAY_W | Current LRU way |

## Verification
The bench builds the block with its defaults: 16 ways, a 16-bit LFSR and a 5-bit coin field. With these values, every way can be hit from every rank position. The bench also runs two thousand bimodal misses, which cover many full coin periods and expose the one-in-32 MRU rate.

The bench keeps a reference order and a reference LFSR of its own. It compares the victim after every access across these runs:

- hit sweeps over every way;
- runs of misses in each mode;
- idle cycles with random inputs;
- a long random mix of all of the above.

Because the victim is compared after every access, any ordering error shows up at the victim port.

// File: rtl/ips_pkg.sv
// Package: types shared by the recency-stack modules.
package ips_pkg;
    typedef enum logic [1:0] {
        INS_MRU     = 2'd0,
        INS_LRU     = 2'd1,
        INS_BIMODAL = 2'd2,
        INS_MRU_ALT = 2'd3
    } ins_mode_e;
endpackage

// File: rtl/ips_lfsr.sv
// Fibonacci LFSR that shifts left and feeds back the XOR of the bits selected by TAPS.
// Assumes TAPS gives a maximal-length sequence and SEED is nonzero.
module ips_lfsr #(
    parameter int                W    = 16,
    parameter logic [W-1:0]      TAPS = 16'hB400,
    parameter logic [W-1:0]      SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);
    // Step the register once per advance request.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= SEED;
        else if (adv) state <= {state[W-2:0], ^(state & TAPS)};
    end

    a_r7_advances: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> state != $past(state));
    a_r9_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));
    a_r7_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/ips_rank_cell.sv
// Holds the recency rank of one way.
// On an update, the target way takes rank 0 and every way younger than the target ages by one.
// Assumes the ranks of all cells together form a permutation.
module ips_rank_cell #(
    parameter int              RW         = 4,
    parameter logic [RW-1:0]   RESET_RANK = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic          is_target,
    input  logic [RW-1:0] target_rank,
    output logic [RW-1:0] rank
);
    // Register the rank; a promotion reorders around the target.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rank <= RESET_RANK;
        else if (upd_en) begin
            if (is_target)            rank <= '0;
            else if (rank < target_rank) rank <= rank + RW'(1);
        end
    end

    a_r3_target_mru: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && is_target |=> rank == '0);
    a_r3_older_kept: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en && !is_target && rank > target_rank |=> $stable(rank));
endmodule

// File: rtl/ips_victim_sel.sv
// Encodes the index of the way whose rank equals the oldest rank (WAYS-1).
// Assumes exactly one way matches, which holds while the ranks form a permutation.
module ips_victim_sel #(
    parameter int WAYS = 16,
    parameter int RW   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WAYS-1:0][RW-1:0]  ranks,
    output logic [RW-1:0]            victim
);
    localparam logic [RW-1:0] OLDEST = RW'(WAYS - 1);

    logic [WAYS-1:0] is_oldest;

    // Compare every rank with the oldest value.
    always_comb begin
        for (int i = 0; i < WAYS; i++) is_oldest[i] = (ranks[i] == OLDEST);
    end

    // Encode the matching way as a binary index.
    always_comb begin
        victim = '0;
        for (int i = 0; i < WAYS; i++)
            if (is_oldest[i]) victim = RW'(i);
    end

    a_r2_single_lru: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(is_oldest));
endmodule

// File: rtl/ips_recency_stack.sv
// Replacement state for one set: a rank per way, a victim encoder and a bimodal coin.
// Assumes WAYS is a power of two. The victim way always carries the line filled on a miss.
module ips_recency_stack #(
    parameter int                 WAYS      = 16,
    parameter int                 WAY_W     = $clog2(WAYS),
    parameter int                 LFSR_W    = 16,
    parameter logic [LFSR_W-1:0]  LFSR_TAPS = 16'hB400,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 16'hACE1,
    parameter int                 EPS_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] hit_way,
    input  logic [1:0]       ins_mode,
    output logic [WAY_W-1:0] victim_way
);
    import ips_pkg::*;

    logic [WAYS-1:0][WAY_W-1:0] ranks;
    logic [LFSR_W-1:0]          lfsr;
    logic                       miss;
    logic                       coin;
    logic                       mru_ins;
    logic                       upd_en;
    logic [WAY_W-1:0]           tgt_way;
    logic [WAY_W-1:0]           tgt_rank;
    ins_mode_e                  mode;

    assign mode = ins_mode_e'(ins_mode);
    assign miss = acc_valid && !acc_hit;
    assign coin = (lfsr[EPS_W-1:0] == '0);

    ips_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (miss),
        .state (lfsr)
    );

    // Decide whether a miss places the new line at MRU.
    always_comb begin
        case (mode)
            INS_LRU:     mru_ins = 1'b0;
            INS_BIMODAL: mru_ins = coin;
            default:     mru_ins = 1'b1;
        endcase
    end

    // Choose the way to promote and the rank it currently holds.
    always_comb begin
        upd_en   = acc_valid && (acc_hit || mru_ins);
        tgt_way  = acc_hit ? hit_way : victim_way;
        tgt_rank = ranks[tgt_way];
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        localparam logic [WAY_W-1:0] INIT = WAY_W'(w);
        ips_rank_cell #(.RW(WAY_W), .RESET_RANK(INIT)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .upd_en      (upd_en),
            .is_target   (tgt_way == INIT),
            .target_rank (tgt_rank),
            .rank        (ranks[w])
        );
    end

    ips_victim_sel #(.WAYS(WAYS), .RW(WAY_W)) u_vsel (
        .clk    (clk),
        .rst_n  (rst_n),
        .ranks  (ranks),
        .victim (victim_way)
    );

    a_r5_lru_slot_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        miss && mode == INS_LRU |=> $stable(victim_way));
    a_r4_mru_insert_moves: assert property (@(posedge clk) disable iff (!rst_n)
        miss && (mode == INS_MRU || mode == INS_MRU_ALT) |=> victim_way != $past(victim_way));
    a_r6_bimodal_tails: assert property (@(posedge clk) disable iff (!rst_n)
        miss && mode == INS_BIMODAL && lfsr[EPS_W-1:0] != '0 |=> $stable(victim_way));
    a_r3_hit_other_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_hit && hit_way != victim_way |=> $stable(victim_way));
    a_r3_hit_victim_moves: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_hit && hit_way == victim_way |=> victim_way != $past(victim_way));
    a_r9_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(victim_way));
endmodule

// File: tb/tb_ips_recency_stack.sv
// Self-checking bench: a reference rank model and LFSR, compared with the victim after every access.
module tb_ips_recency_stack;
    localparam int WAYS = 16;
    localparam int WW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_hit = 1'b0;
    logic [WW-1:0] hit_way = '0;
    logic [1:0]    ins_mode = 2'd0;
    logic [WW-1:0] victim_way;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int m_rank [WAYS];
    logic [15:0] m_lfsr;
    int bim_promos;

    always #5 clk = ~clk;

    ips_recency_stack dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
        .hit_way(hit_way), .ins_mode(ins_mode), .victim_way(victim_way)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d cycles expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int model_victim();
        int v = 0;
        for (int i = 0; i < WAYS; i++) if (m_rank[i] == WAYS - 1) v = i;
        return v;
    endfunction

    task automatic check_victim(input string tag);
        int exp_v = model_victim();
        checks++;
        if (victim_way !== WW'(exp_v)) begin
            errors++;
            $display("FAIL %s victim actual=%0d expected=%0d", tag, victim_way, exp_v);
        end
    endtask

    task automatic model_promote(input int tgt);
        int tr = m_rank[tgt];
        for (int i = 0; i < WAYS; i++) begin
            if (i == tgt)          m_rank[i] = 0;
            else if (m_rank[i] < tr) m_rank[i] = m_rank[i] + 1;
        end
    endtask

    // Drive one cycle of inputs, update the model, and check at the next falling edge.
    task automatic access(input logic v, input logic h, input int w, input int md, input string tag);
        bit promote;
        int tgt;
        acc_valid = v; acc_hit = h; hit_way = WW'(w); ins_mode = 2'(md);
        @(posedge clk);
        if (v) begin
            if (h) begin
                promote = 1'b1; tgt = w;
            end else begin
                tgt = model_victim();
                case (md)
                    1:       promote = 1'b0;
                    2:       promote = (m_lfsr[4:0] == 5'd0);
                    default: promote = 1'b1;
                endcase
                if (md == 2 && promote) bim_promos++;
                m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
            end
            if (promote) model_promote(tgt);
        end
        @(negedge clk);
        acc_valid = 1'b0;
        check_victim(tag);
    endtask

    initial begin
        for (int i = 0; i < WAYS; i++) m_rank[i] = i;
        m_lfsr = 16'hACE1;
        bim_promos = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_victim("R1 reset");

        // R3: hit every way at each position, then hit the current victim.
        for (int r = 0; r < 4; r++)
            for (int w = 0; w < WAYS; w++) access(1, 1, (w * 5 + r) % WAYS, 0, "R3 hit sweep");
        for (int i = 0; i < 20; i++) access(1, 1, model_victim(), 0, "R3 hit victim");

        // R4 / R8: conventional misses walk through the order.
        for (int i = 0; i < 20; i++) access(1, 0, 0, 0, "R4 mru insert");
        for (int i = 0; i < 20; i++) access(1, 0, 0, 3, "R8 alt mode");

        // R5 / R7: LRU-slot misses keep the order but still advance the LFSR.
        for (int i = 0; i < 37; i++) access(1, 0, 0, 1, "R5 lru insert");

        // R9: idle cycles with noisy inputs change nothing.
        for (int i = 0; i < 30; i++) access(0, $urandom_range(0, 1), $urandom_range(0, 15), $urandom_range(0, 3), "R9 idle");

        // R6: bimodal misses.
        for (int i = 0; i < 2000; i++) access(1, 0, 0, 2, "R6 bimodal");
        checks++;
        if (bim_promos < 20 || bim_promos > 150) begin
            errors++;
            $display("FAIL R6 bimodal promotions actual=%0d expected=20..150", bim_promos);
        end

        // R2 / R7 / R10: random mix of all modes and kinds.
        for (int i = 0; i < 4000; i++)
            access($urandom_range(0, 7) != 0, $urandom_range(0, 1), $urandom_range(0, 15),
                   $urandom_range(0, 3), "R2 R7 R10 mixed");

        // R1: reset again in mid-run.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < WAYS; i++) m_rank[i] = i;
        m_lfsr = 16'hACE1;
        check_victim("R1 re-reset");
        for (int i = 0; i < 64; i++) access(1, 0, 0, 2, "R7 reseeded");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule